// File: doc/BRIEF.md
# Serial Debug Command Port

This block lets an external debugger stop a processor core and inspect or change a small bank of core-visible registers over a three-wire serial link: a debug clock, a data input and a debug request. Every wire is brought into the system clock domain through a two-stage synchronizer, and the block finds edges only after that point. The block answers on a single serial output line. The same line carries a short acknowledge pulse when debug mode begins and then the contents of any register the debugger reads. A two-bit status output tells the debugger whether the core is running normally, stopped, waiting or held in debug mode.

A debug session begins when the request input rises. The port then raises a halt request towards the core. If the core is in its low-power wait state, the port also asks it to wake. Debug mode starts only after the core reports that it has halted and has left the wait state. After the acknowledge pulse, the debugger sends 8-bit commands, most significant bit first, sampled on the falling edges of the debug clock. A write command is followed by 24 data bits. A read command is followed by 24 debug-clock cycles during which the addressed register is shifted out. A command may ask to leave debug mode once its data phase ends. The core also has its own read port and write port into the same register bank.

The controller is one state machine with seven states. IDLE is normal operation. HALT waits for the core to halt. ACK drives the acknowledge pulse. CMD collects a command byte. WDATA collects write data. RDATA shifts read data out. RESUME waits for the core to run again. The transitions are:
- IDLE to HALT on a request rise.
- HALT to ACK once the core is halted and not waiting.
- ACK to CMD after the pulse length.
- CMD to WDATA or RDATA on the eighth falling edge.
- WDATA or RDATA back to CMD on the 24th falling edge.
- WDATA or RDATA to RESUME instead, when the exit bit was set.
- RESUME to IDLE when the core drops its halted flag.

Top module: `dbg_serial_port`

## Requirements
- R1: `proc_state_o` reads 2'b11 while debug mode is active (states ACK, CMD, WDATA, RDATA). Otherwise it reads 2'b01 when `core_stop_i` is high, else 2'b10 when `core_wait_i` is high, else 2'b00.
- R2: A rising edge of the synchronized request while in IDLE raises `halt_req_o`. Debug mode is entered only once `core_halted_i` is high and `core_wait_i` is low.
- R3: On entry to debug mode, `dbg_dout_o` is high for exactly ACK_LEN system clock cycles (default 4) and then goes low.
- R4: While a halt is pending and `core_wait_i` is high, `wake_o` is high and no acknowledge is driven. The acknowledge follows only after the wait state ends.
- R5: Serial input is sampled on falling edges of the synchronized debug clock, most significant bit first. In the command byte, bit 7 = 1 means read and 0 means write, bit 6 = 1 requests exit, bits 4:0 hold the register address, and bit 5 is ignored.
- R6: After a write command, the next 24 bits, MSB first, are stored into the addressed register when the 24th bit is sampled.
- R7: After a read command, `dbg_dout_o` presents bit 23 of the addressed register before the next falling edge. Each following falling edge advances one bit. After 24 edges the port expects a new command.
- R8: `dbg_dout_o` is low whenever debug mode is not active, and also during the command and write-data phases.
- R9: When the exit bit was set, `halt_req_o` falls at the end of that command's data phase. The port returns to normal status after `core_halted_i` falls.
- R10: Addresses at or above NREGS (default 8) read as zero, and writes to them are discarded.
- R11: If the debugger write and the core write hit the same register in the same cycle, the debugger value is stored.
- R12: Debug clock and data activity outside debug mode changes no register and leaves the serial output low.
- R13: `core_rdata_o` combinationally returns the register selected by `core_raddr_i`. A core write is stored at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_clk_i | input | 1 | Serial debug clock from the debugger |
| dbg_din_i | input | 1 | Serial command and data input |
| dbg_req_i | input | 1 | Debug request, rising edge starts a session |
| dbg_dout_o | output | 1 | Acknowledge pulse and read data; low when idle |
| proc_state_o | output | 2 | Processor status: 00 normal, 01 stopped, 10 waiting, 11 debug |
| core_stop_i | input | 1 | Core is in its stop state |
| core_wait_i | input | 1 | Core is in its wait state |
| core_halted_i | input | 1 | Core has halted on request |
| halt_req_o | output | 1 | Request for the core to halt |
| wake_o | output | 1 | Request for the core to leave its wait state |
| core_we_i | input | 1 | Core register write enable |
| core_waddr_i | input | 5 | Core register write address |
| core_wdata_i | input | 24 | Core register write data |
| core_raddr_i | input | 5 | Core register read address |
| core_rdata_o | output | 24 | Core register read data |

## Verification
The debugger's register write and the core's own write port can target the same register in the same system clock cycle. The bench provokes this by counting from the final falling debug-clock edge of a write: the first two system edges pass through the synchronizer, and the third edge commits the data. The bench asserts the core write enable for exactly that one cycle, with a different value. It judges the result through both the core read port and a later serial read, and both must show the debugger's value.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HALT,
        ST_ACK,
        ST_CMD,
        ST_WDATA,
        ST_RDATA,
        ST_RESUME
    } dbgp_state_e;

    localparam logic [1:0] PS_NORMAL = 2'b00;
    localparam logic [1:0] PS_STOP   = 2'b01;
    localparam logic [1:0] PS_WAIT   = 2'b10;
    localparam logic [1:0] PS_DEBUG  = 2'b11;

    localparam int CMD_BITS     = 8;
    localparam int CMD_RD_BIT   = 7;
    localparam int CMD_EXIT_BIT = 6;
    localparam int ADDR_BITS    = 5;

endpackage

// File: rtl/dbgp_sync.sv
module dbgp_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        logic prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= d_i[g];
                stab_q <= meta_q;
                prev_q <= stab_q;
            end
        end

        assign q_o[g]    = stab_q;
        assign rise_o[g] = stab_q & ~prev_q;
        assign fall_o[g] = ~stab_q & prev_q;
    end

endmodule

// File: rtl/dbgp_shreg.sv
module dbgp_shreg #(
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] load_val_i,
    input  logic          shift_i,
    input  logic          sin_i,
    output logic [DW-1:0] q_o
);

    logic [DW-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (load_i) begin
            sh_q <= load_val_i;
        end else if (shift_i) begin
            sh_q <= {sh_q[DW-2:0], sin_i};
        end
    end

    assign q_o = sh_q;

endmodule

// File: rtl/dbgp_regfile.sv
module dbgp_regfile #(
    parameter int DW    = 24,
    parameter int NREGS = 8,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbg_we_i,
    input  logic [AW-1:0] dbg_waddr_i,
    input  logic [DW-1:0] dbg_wdata_i,
    input  logic [AW-1:0] dbg_raddr_i,
    output logic [DW-1:0] dbg_rdata_o,
    input  logic          core_we_i,
    input  logic [AW-1:0] core_waddr_i,
    input  logic [DW-1:0] core_wdata_i,
    input  logic [AW-1:0] core_raddr_i,
    output logic [DW-1:0] core_rdata_o
);

    logic [NREGS-1:0][DW-1:0] mem_q;

    // Debugger write has priority over a core write to the same entry.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                if (dbg_we_i && dbg_waddr_i == AW'(i)) begin
                    mem_q[i] <= dbg_wdata_i;
                end else if (core_we_i && core_waddr_i == AW'(i)) begin
                    mem_q[i] <= core_wdata_i;
                end
            end
        end
    end

    // Out-of-range addresses match no entry and read as zero.
    always_comb begin
        dbg_rdata_o  = '0;
        core_rdata_o = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (dbg_raddr_i == AW'(i)) begin
                dbg_rdata_o = mem_q[i];
            end
            if (core_raddr_i == AW'(i)) begin
                core_rdata_o = mem_q[i];
            end
        end
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_chk
        p_dbg_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (dbg_we_i && dbg_waddr_i == AW'(g) && core_we_i && core_waddr_i == AW'(g))
            |=> (mem_q[g] == $past(dbg_wdata_i)));
    end

endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
    import dbgp_pkg::*;
#(
    parameter int DW      = 24,
    parameter int NREGS   = 8,
    parameter int ACK_LEN = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dbg_clk_i,
    input  logic                 dbg_din_i,
    input  logic                 dbg_req_i,
    output logic                 dbg_dout_o,
    output logic [1:0]           proc_state_o,
    input  logic                 core_stop_i,
    input  logic                 core_wait_i,
    input  logic                 core_halted_i,
    output logic                 halt_req_o,
    output logic                 wake_o,
    input  logic                 core_we_i,
    input  logic [ADDR_BITS-1:0] core_waddr_i,
    input  logic [DW-1:0]        core_wdata_i,
    input  logic [ADDR_BITS-1:0] core_raddr_i,
    output logic [DW-1:0]        core_rdata_o
);

    localparam int CNT_MAX = (DW > CMD_BITS) ? DW : CMD_BITS;
    localparam int CW      = $clog2(CNT_MAX);
    localparam int AKW     = $clog2(ACK_LEN + 1);
    localparam logic [CW-1:0]  CMD_LAST  = CW'(CMD_BITS - 1);
    localparam logic [CW-1:0]  DATA_LAST = CW'(DW - 1);
    localparam logic [AKW-1:0] ACK_LAST  = AKW'(ACK_LEN - 1);

    // Synchronized serial inputs: bit 0 clock, bit 1 data, bit 2 request
    logic [2:0] sync_q;
    logic [2:0] sync_rise;
    logic [2:0] sync_fall;

    dbgp_sync #(.W(3)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({dbg_req_i, dbg_din_i, dbg_clk_i}),
        .q_o    (sync_q),
        .rise_o (sync_rise),
        .fall_o (sync_fall)
    );

    logic sck_fall;
    logic din_s;
    logic req_rise;
    assign sck_fall = sync_fall[0];
    assign din_s    = sync_q[1];
    assign req_rise = sync_rise[2];

    dbgp_state_e           state_q;
    dbgp_state_e           state_d;
    logic [CW-1:0]         bitcnt_q;
    logic [AKW-1:0]        ack_cnt_q;
    logic                  exit_q;
    logic [ADDR_BITS-1:0]  addr_q;

    logic [DW-1:0]         sh_q;
    logic                  sh_load;
    logic                  sh_shift;
    logic                  sh_sin;
    logic [CMD_BITS-1:0]   cmd_now;
    logic                  cmd_done;
    logic                  data_phase;

    logic                  rf_we;
    logic [DW-1:0]         rf_wdata;
    logic [DW-1:0]         rf_rdata;

    logic                  dbg_active;

    assign cmd_now    = {sh_q[CMD_BITS-2:0], din_s};
    assign cmd_done   = (state_q == ST_CMD) && sck_fall && (bitcnt_q == CMD_LAST);
    assign data_phase = (state_q == ST_WDATA) || (state_q == ST_RDATA);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_rise) state_d = ST_HALT;
            end
            ST_HALT: begin
                if (core_halted_i && !core_wait_i) state_d = ST_ACK;
            end
            ST_ACK: begin
                if (ack_cnt_q == ACK_LAST) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (cmd_done) state_d = cmd_now[CMD_RD_BIT] ? ST_RDATA : ST_WDATA;
            end
            ST_WDATA, ST_RDATA: begin
                if (sck_fall && bitcnt_q == DATA_LAST) state_d = exit_q ? ST_RESUME : ST_CMD;
            end
            ST_RESUME: begin
                if (!core_halted_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Counters and latched command fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q  <= '0;
            ack_cnt_q <= '0;
            exit_q    <= 1'b0;
            addr_q    <= '0;
        end else begin
            if (state_q != state_d) begin
                bitcnt_q <= '0;
            end else if (sck_fall && (state_q == ST_CMD || data_phase)) begin
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            ack_cnt_q <= (state_q == ST_ACK) ? ack_cnt_q + 1'b1 : '0;
            if (cmd_done) begin
                exit_q <= cmd_now[CMD_EXIT_BIT];
                addr_q <= cmd_now[ADDR_BITS-1:0];
            end
        end
    end

    // Shift register control
    always_comb begin
        sh_load  = cmd_done && cmd_now[CMD_RD_BIT];
        sh_shift = sck_fall && (state_q == ST_CMD || data_phase);
        sh_sin   = (state_q == ST_RDATA) ? 1'b0 : din_s;
        rf_we    = (state_q == ST_WDATA) && sck_fall && (bitcnt_q == DATA_LAST);
        rf_wdata = {sh_q[DW-2:0], din_s};
    end

    dbgp_shreg #(.DW(DW)) u_shreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_val_i (rf_rdata),
        .shift_i    (sh_shift),
        .sin_i      (sh_sin),
        .q_o        (sh_q)
    );

    dbgp_regfile #(.DW(DW), .NREGS(NREGS), .AW(ADDR_BITS)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .dbg_we_i     (rf_we),
        .dbg_waddr_i  (addr_q),
        .dbg_wdata_i  (rf_wdata),
        .dbg_raddr_i  (cmd_now[ADDR_BITS-1:0]),
        .dbg_rdata_o  (rf_rdata),
        .core_we_i    (core_we_i),
        .core_waddr_i (core_waddr_i),
        .core_wdata_i (core_wdata_i),
        .core_raddr_i (core_raddr_i),
        .core_rdata_o (core_rdata_o)
    );

    // Output logic
    always_comb begin
        dbg_active = 1'b0;
        halt_req_o = 1'b0;
        wake_o     = 1'b0;
        dbg_dout_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_RESUME: begin
            end
            ST_HALT: begin
                halt_req_o = 1'b1;
                wake_o     = core_wait_i;
            end
            ST_ACK: begin
                halt_req_o = 1'b1;
                dbg_active = 1'b1;
                dbg_dout_o = 1'b1;
            end
            ST_CMD, ST_WDATA: begin
                halt_req_o = 1'b1;
                dbg_active = 1'b1;
            end
            ST_RDATA: begin
                halt_req_o = 1'b1;
                dbg_active = 1'b1;
                dbg_dout_o = sh_q[DW-1];
            end
            default: begin
            end
        endcase
        if (dbg_active)       proc_state_o = PS_DEBUG;
        else if (core_stop_i) proc_state_o = PS_STOP;
        else if (core_wait_i) proc_state_o = PS_WAIT;
        else                  proc_state_o = PS_NORMAL;
    end

    p_dso_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (proc_state_o != PS_DEBUG) |-> !dbg_dout_o);

    p_halt_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && !core_halted_i) |=> (state_q == ST_HALT));

    p_no_ack_in_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && core_wait_i) |=> !dbg_dout_o);

    p_ack_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACK) |-> (ack_cnt_q < AKW'(ACK_LEN)));

    p_cmd_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CMD) |-> (bitcnt_q <= CMD_LAST));

    p_exit_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && sck_fall && bitcnt_q == DATA_LAST && exit_q) |=> !halt_req_o);

endmodule

// File: tb/dbg_serial_port_bench.sv
module dbg_serial_port_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 24;
    localparam int NREGS      = 8;
    localparam int ACK_LEN    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dsck = 1'b0;
    logic          dsi = 1'b0;
    logic          dreq = 1'b0;
    logic          dso;
    logic [1:0]    pstate;
    logic          core_stop = 1'b0;
    logic          core_wait = 1'b0;
    logic          core_halted;
    logic          halt_req;
    logic          wake;
    logic          core_we = 1'b0;
    logic [4:0]    core_waddr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic [4:0]    core_raddr = '0;
    logic [DW-1:0] core_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [DW-1:0] model [NREGS];

    always #(CLK_PERIOD/2) clk = ~clk;

    // Simple core: halts one cycle after the request unless it is waiting.
    always @(posedge clk) begin
        if (!rst_n) core_halted <= 1'b0;
        else        core_halted <= halt_req && !core_wait;
    end

    dbg_serial_port #(.DW(DW), .NREGS(NREGS), .ACK_LEN(ACK_LEN)) u_dbg_serial_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .dbg_clk_i     (dsck),
        .dbg_din_i     (dsi),
        .dbg_req_i     (dreq),
        .dbg_dout_o    (dso),
        .proc_state_o  (pstate),
        .core_stop_i   (core_stop),
        .core_wait_i   (core_wait),
        .core_halted_i (core_halted),
        .halt_req_o    (halt_req),
        .wake_o        (wake),
        .core_we_i     (core_we),
        .core_waddr_i  (core_waddr),
        .core_wdata_i  (core_wdata),
        .core_raddr_i  (core_raddr),
        .core_rdata_o  (core_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b, output logic so);
        @(negedge clk);
        dsck = 1'b1;
        dsi  = b;
        repeat (4) @(negedge clk);
        so   = dso;
        dsck = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_cmd(input logic rd, input logic ex, input logic b5, input logic [4:0] a);
        logic [7:0] c;
        logic so;
        logic acc;
        c   = {rd, ex, b5, a};
        acc = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            shift_bit(c[i], so);
            acc |= so;
        end
        check("R8 output low during command", 32'(acc), 32'd0);
    endtask

    task automatic ser_write(input logic [4:0] a, input logic [DW-1:0] d, input logic ex);
        logic so;
        logic acc;
        send_cmd(1'b0, ex, 1'b0, a);
        acc = 1'b0;
        for (int i = DW-1; i >= 0; i--) begin
            shift_bit(d[i], so);
            acc |= so;
        end
        check("R8 output low during write data", 32'(acc), 32'd0);
        if (a < NREGS) model[a] = d;
    endtask

    task automatic ser_read(input logic [4:0] a, input logic ex, input logic b5, output logic [DW-1:0] v);
        logic so;
        send_cmd(1'b1, ex, b5, a);
        for (int i = DW-1; i >= 0; i--) begin
            shift_bit(1'b0, so);
            v[i] = so;
        end
    endtask

    task automatic core_read(input logic [4:0] a, output logic [DW-1:0] v);
        @(negedge clk);
        core_raddr = a;
        #1;
        v = core_rdata;
    endtask

    task automatic core_write(input logic [4:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        core_we    = 1'b1;
        core_waddr = a;
        core_wdata = d;
        @(negedge clk);
        core_we    = 1'b0;
        if (a < NREGS) model[a] = d;
    endtask

    task automatic wait_ack(input string tag);
        int guard;
        int len;
        guard = 0;
        while (dso !== 1'b1 && guard < 300) begin
            @(negedge clk);
            guard++;
        end
        check({tag, " R2 halt request raised"}, 32'(halt_req), 32'd1);
        check({tag, " R1 debug status during acknowledge"}, 32'(pstate), 32'd3);
        len = 0;
        while (dso === 1'b1 && len < 50) begin
            len++;
            @(negedge clk);
        end
        check({tag, " R3 acknowledge length"}, 32'(len), 32'(ACK_LEN));
        dreq = 1'b0;
    endtask

    task automatic t_reset;
        logic [DW-1:0] v;
        check("R1 status after reset", 32'(pstate), 32'd0);
        check("R8 output low after reset", 32'(dso), 32'd0);
        check("R2 no halt request after reset", 32'(halt_req), 32'd0);
        core_read(5'd0, v);
        check("R13 register zero after reset", 32'(v), 32'd0);
    endtask

    task automatic t_status;
        @(negedge clk); core_stop = 1'b1; #1;
        check("R1 stopped status", 32'(pstate), 32'd1);
        core_wait = 1'b1; #1;
        check("R1 stop has priority over wait", 32'(pstate), 32'd1);
        core_stop = 1'b0; #1;
        check("R1 waiting status", 32'(pstate), 32'd2);
        core_wait = 1'b0; #1;
        check("R1 normal status", 32'(pstate), 32'd0);
    endtask

    task automatic t_idle_ignore(input string tag);
        logic so;
        logic acc;
        logic [DW-1:0] v;
        acc = 1'b0;
        for (int i = 0; i < 20; i++) begin
            shift_bit(logic'((i % 3) == 0), so);
            acc |= so;
        end
        check({tag, " R12 output low while idle"}, 32'(acc), 32'd0);
        check({tag, " R12 no halt request from serial activity"}, 32'(halt_req), 32'd0);
        core_read(5'd3, v);
        check({tag, " R12 register unchanged"}, 32'(v), 32'(model[3]));
    endtask

    task automatic t_enter;
        @(negedge clk);
        dreq = 1'b1;
        wait_ack("enter");
    endtask

    task automatic t_write_read;
        logic [DW-1:0] v;
        ser_write(5'd1, 24'hA5C3F0, 1'b0);
        ser_write(5'd5, 24'h0F1E2D, 1'b0);
        ser_read(5'd1, 1'b0, 1'b0, v);
        check("R6 R7 serial read of reg1", 32'(v), 32'h00A5C3F0);
        ser_read(5'd5, 1'b0, 1'b0, v);
        check("R6 R7 serial read of reg5", 32'(v), 32'h000F1E2D);
        ser_read(5'd1, 1'b0, 1'b1, v);
        check("R5 command bit 5 ignored", 32'(v), 32'h00A5C3F0);
        ser_read(5'd3, 1'b0, 1'b0, v);
        check("R13 core-written value read serially", 32'(v), 32'(model[3]));
        core_read(5'd5, v);
        check("R13 core port sees debugger write", 32'(v), 32'h000F1E2D);
    endtask

    task automatic t_oob;
        logic [DW-1:0] v;
        ser_write(5'd20, 24'h777777, 1'b0);
        ser_read(5'd20, 1'b0, 1'b0, v);
        check("R10 out-of-range read is zero", 32'(v), 32'd0);
        ser_read(5'd4, 1'b0, 1'b0, v);
        check("R10 out-of-range write discarded", 32'(v), 32'(model[4]));
    endtask

    task automatic t_collide;
        logic so;
        logic [DW-1:0] d;
        logic [DW-1:0] v;
        d = 24'h3C5A96;
        send_cmd(1'b0, 1'b0, 1'b0, 5'd4);
        for (int i = DW-1; i >= 1; i--) shift_bit(d[i], so);
        @(negedge clk);
        dsck = 1'b1;
        dsi  = d[0];
        repeat (4) @(negedge clk);
        dsck = 1'b0;
        repeat (2) @(negedge clk);
        core_we    = 1'b1;
        core_waddr = 5'd4;
        core_wdata = 24'h111111;
        @(negedge clk);
        core_we = 1'b0;
        repeat (4) @(negedge clk);
        model[4] = d;
        core_read(5'd4, v);
        check("R11 debugger wins same-cycle write (core port)", 32'(v), 32'(d));
        ser_read(5'd4, 1'b0, 1'b0, v);
        check("R11 debugger wins same-cycle write (serial)", 32'(v), 32'(d));
        core_write(5'd6, 24'hBEEF01);
        core_read(5'd6, v);
        check("R13 core write stored", 32'(v), 32'h00BEEF01);
    endtask

    task automatic t_exit;
        logic [DW-1:0] v;
        ser_read(5'd1, 1'b1, 1'b0, v);
        check("R7 read with exit returns data", 32'(v), 32'(model[1]));
        repeat (8) @(negedge clk);
        check("R9 halt request released", 32'(halt_req), 32'd0);
        check("R9 normal status after exit", 32'(pstate), 32'd0);
        check("R8 output low after exit", 32'(dso), 32'd0);
    endtask

    task automatic t_wake;
        @(negedge clk);
        core_wait = 1'b1;
        #1;
        check("R1 waiting before request", 32'(pstate), 32'd2);
        dreq = 1'b1;
        repeat (8) @(negedge clk);
        check("R4 wake asserted while waiting", 32'(wake), 32'd1);
        check("R4 halt request while waiting", 32'(halt_req), 32'd1);
        repeat (10) begin
            @(negedge clk);
            check("R4 no acknowledge while waiting", 32'(dso), 32'd0);
        end
        check("R2 not in debug while waiting", 32'(pstate), 32'd2);
        core_wait = 1'b0;
        wait_ack("wake");
        check("R4 wake dropped after recovery", 32'(wake), 32'd0);
        ser_write(5'd2, 24'h5A5A5A, 1'b1);
        repeat (8) @(negedge clk);
        check("R9 exit after write", 32'(halt_req), 32'd0);
        check("R9 normal status after write exit", 32'(pstate), 32'd0);
        core_raddr = 5'd2;
        #1;
        check("R6 write with exit stored", 32'(core_rdata), 32'h005A5A5A);
    endtask

    initial begin
        for (int i = 0; i < NREGS; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_status();
        core_write(5'd3, 24'h123456);
        t_idle_ignore("before session");
        t_enter();
        t_write_read();
        t_oob();
        t_collide();
        t_exit();
        t_idle_ignore("after session");
        t_wake();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule